// File: doc/BRIEF.md
# Serial Link Power-State Controller

This block steps one serial link through its power states: fully off, waking, running at the lowest rate on a fixed rail, running at a selected rate on the adaptive rail, and retuning to a new rate. A shutdown decision unit drives level sleep requests and pulsed wake requests. The link reports receiver lock and adaptive-supply stability. The controller drives the transmitter and receiver enables, the rail selection, the rate index, the wake training pattern and a gate that allows payload data only when the link can carry it.

To wake, the transmitter sends a training pattern while both ends run from the fixed 1 V rail at the lowest rate. Receiver lock is the far end's answer, and data may flow from the next cycle, before the adaptive supply has settled. The link moves to the adaptive rail once that supply reports stable, and only then may a higher rate be chosen. A rate change blocks data until the receiver has lost lock and then regained it with the supply stable. A shutdown waits until no transfer is in progress. Each waiting state has a cycle limit. A timeout drops the link to off and raises an error flag.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no wake request, the link is off: both enables, training, adaptive rail, data gate and error flag are 0, and the rate index is 0.
- R2: A wake request in the off state enters waking on the next edge: both enables and training are 1, the fixed rail is selected (sup_adapt_o = 0), the rate index is 0 and the data gate is 0.
- R3: The data gate rises only on the edge after rx_lock_i is seen high. While waking without lock it stays 0. On leaving waking, training stops and the link runs at index 0 on the fixed rail with data allowed.
- R4: In the minimum-rate state the rate index stays 0 whatever rate is requested. supply_ok_i moves the link onto the adaptive rail (sup_adapt_o = 1) at index 0.
- R5: When running and the target rate differs from the current index, on the next edge the index takes the target and the data gate falls. Data resumes only after rx_lock_i has been seen low in an earlier cycle and is then high together with supply_ok_i.
- R6: Rate indices run from 0 (lowest) to NUM_RATES-1 (highest). A request above NUM_RATES-1 is treated as NUM_RATES-1, and a request equal to the current index causes no change.
- R7: A sleep request in the minimum-rate or running state has no effect while tx_busy_i is 1. Once tx_busy_i is 0, every output except the error flag goes to 0 on the next edge. The link stays in the shutdown state for DOWN_CYC cycles and then enters off.
- R8: A wake request that arrives during the shutdown state is held. The link spends one cycle in off and then starts waking.
- R9: If waking lasts LOCK_TMO cycles without lock, the link goes off and err_o rises. err_o stays high until the next wake begins.
- R10: If the minimum-rate state lasts SETTLE_TMO cycles without supply_ok_i, the link goes off with err_o high.
- R11: If a rate change lasts LOCK_TMO cycles without completing, the link goes off with err_o high. This includes the case where lock never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Shutdown request (level) |
| wake_req_i | input | 1 | Wake request (pulse) |
| rate_req_i | input | RATE_W | Requested rate index |
| tx_busy_i | input | 1 | Transmission in progress |
| rx_lock_i | input | 1 | Receiver locked / wake response |
| supply_ok_i | input | 1 | Adaptive supply stable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| tx_train_o | output | 1 | Transmitter sends wake training pattern |
| sup_adapt_o | output | 1 | 1 = adaptive rail, 0 = fixed 1 V rail |
| freq_o | output | RATE_W | Current rate index |
| data_ok_o | output | 1 | Data transfer allowed |
| err_o | output | 1 | Lock or settle timeout occurred |

## Verification
The bench goes after the edges of the wake handshake: a design that let data through before lock, or that moved to the adaptive rail or a higher rate before the supply settled, would show the wrong gate, rail or index in the waking and minimum-rate cycles. A rate change is held with lock kept high, so a design that ends a change on stale lock exits too early. Requests above the top index and repeated requests catch clamping and spurious retunes. A sleep request under a busy transmitter, a wake pulse during shutdown, and each of the three timeouts counted to the exact cycle catch lost or early transitions and an error flag that clears at the wrong time.

// File: rtl/link_pwr_pkg.sv
`timescale 1ns/1ps
package link_pwr_pkg;
  typedef enum logic [2:0] {
    LS_OFF  = 3'd0,
    LS_WAKE = 3'd1,
    LS_MIN  = 3'd2,
    LS_RUN  = 3'd3,
    LS_CHG  = 3'd4,
    LS_DOWN = 3'd5
  } lnk_state_e;
endpackage

// File: rtl/link_pwr_timer.sv
`timescale 1ns/1ps
module link_pwr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/link_rate_sel.sv
`timescale 1ns/1ps
module link_rate_sel #(
  parameter int NUM_RATES = 7,
  parameter int RATE_W    = 3
) (
  input  logic [RATE_W-1:0] req_i,
  input  logic [RATE_W-1:0] cur_i,
  output logic [RATE_W-1:0] tgt_o,
  output logic              diff_o
);
  localparam logic [RATE_W-1:0] TOP = RATE_W'(NUM_RATES - 1);

  assign tgt_o  = (req_i > TOP) ? TOP : req_i;
  assign diff_o = (tgt_o != cur_i);
endmodule

// File: rtl/link_pwr_ctrl.sv
`timescale 1ns/1ps
module link_pwr_ctrl
  import link_pwr_pkg::*;
#(
  parameter int NUM_RATES  = 7,
  parameter int LOCK_TMO   = 64,
  parameter int SETTLE_TMO = 128,
  parameter int DOWN_CYC   = 4,
  localparam int RATE_W    = $clog2(NUM_RATES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              wake_req_i,
  input  logic [RATE_W-1:0] rate_req_i,
  input  logic              tx_busy_i,
  input  logic              rx_lock_i,
  input  logic              supply_ok_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              tx_train_o,
  output logic              sup_adapt_o,
  output logic [RATE_W-1:0] freq_o,
  output logic              data_ok_o,
  output logic              err_o
);
  localparam int MAX_T_A = (LOCK_TMO > SETTLE_TMO) ? LOCK_TMO : SETTLE_TMO;
  localparam int MAX_T   = (MAX_T_A > DOWN_CYC) ? MAX_T_A : DOWN_CYC;
  localparam int CNT_W   = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] LOCK_LIM   = CNT_W'(LOCK_TMO - 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_TMO - 1);
  localparam logic [CNT_W-1:0] DOWN_LIM   = CNT_W'(DOWN_CYC - 1);

  lnk_state_e        state_q, state_d;
  logic              pend_q, err_q, drop_q;
  logic [RATE_W-1:0] freq_q, rate_tgt;
  logic              rate_diff, tmo, sleep_ok, tmo_exit;
  logic [CNT_W-1:0]  lim;

  link_rate_sel #(.NUM_RATES(NUM_RATES), .RATE_W(RATE_W)) u_rate_sel (
    .req_i (rate_req_i),
    .cur_i (freq_q),
    .tgt_o (rate_tgt),
    .diff_o(rate_diff)
  );

  always_comb begin
    case (state_q)
      LS_DOWN: lim = DOWN_LIM;
      LS_MIN:  lim = SETTLE_LIM;
      default: lim = LOCK_LIM;
    endcase
  end

  link_pwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_d != state_q),
    .limit_i  (lim),
    .expired_o(tmo)
  );

  assign sleep_ok = sleep_req_i && !tx_busy_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LS_OFF:  if (wake_req_i || pend_q) state_d = LS_WAKE;
      LS_WAKE: if (rx_lock_i) state_d = LS_MIN;
               else if (tmo) state_d = LS_OFF;
      LS_MIN:  if (sleep_ok) state_d = LS_DOWN;
               else if (supply_ok_i) state_d = LS_RUN;
               else if (tmo) state_d = LS_OFF;
      LS_RUN:  if (sleep_ok) state_d = LS_DOWN;
               else if (rate_diff) state_d = LS_CHG;
      // relock must follow a seen loss of lock
      LS_CHG:  if (drop_q && rx_lock_i && supply_ok_i) state_d = LS_RUN;
               else if (tmo) state_d = LS_OFF;
      LS_DOWN: if (tmo) state_d = LS_OFF;
      default: state_d = LS_OFF;
    endcase
  end

  assign tmo_exit = (state_d == LS_OFF) &&
                    (state_q == LS_WAKE || state_q == LS_MIN || state_q == LS_CHG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LS_OFF;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      drop_q  <= 1'b0;
      freq_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == LS_OFF)                      pend_q <= 1'b0;
      else if (state_q == LS_DOWN && wake_req_i)  pend_q <= 1'b1;
      if (tmo_exit)                               err_q <= 1'b1;
      else if (state_d == LS_WAKE)                err_q <= 1'b0;
      if (state_q != LS_CHG)                      drop_q <= 1'b0;
      else if (!rx_lock_i)                        drop_q <= 1'b1;
      if (state_d == LS_CHG && state_q != LS_CHG) freq_q <= rate_tgt;
      else if (state_d != LS_RUN && state_d != LS_CHG) freq_q <= '0;
    end
  end

  assign tx_en_o     = (state_q == LS_WAKE) || (state_q == LS_MIN) ||
                       (state_q == LS_RUN)  || (state_q == LS_CHG);
  assign rx_en_o     = tx_en_o;
  assign tx_train_o  = (state_q == LS_WAKE);
  assign sup_adapt_o = (state_q == LS_RUN) || (state_q == LS_CHG);
  assign data_ok_o   = (state_q == LS_MIN) || (state_q == LS_RUN);
  assign freq_o      = freq_q;
  assign err_o       = err_q;

  a_r3_data_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_ok_o) |-> $past(rx_lock_i));
  a_r4_min_rate_fixed_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !sup_adapt_o) |-> (freq_o == '0));
  a_r4_adapt_after_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sup_adapt_o) |-> $past(supply_ok_i));
  a_r5_no_data_on_retune: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_o != $past(freq_o)) |-> !data_ok_o);
  a_r6_freq_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(freq_o) < NUM_RATES);
  a_r7_sleep_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> (err_o || !$past(tx_busy_i)));
  a_r9_err_only_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !tx_en_o);
endmodule

// File: tb/link_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_pwr_ctrl_tb_top;
  localparam int NR = 7;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req = 0, wake_req = 0, tx_busy = 0, rx_lock = 0, supply_ok = 0;
  logic [RW-1:0] rate_req = '0;
  logic tx_en, rx_en, tx_train, sup_adapt, data_ok, err;
  logic [RW-1:0] freq;
  int checks = 0, errors = 0;

  localparam int V_REQ [7] = '{7, 0, 3, 3, 6, 7, 1};
  localparam int V_EXP [7] = '{6, 0, 3, 3, 6, 6, 1};

  always #5 clk = ~clk;

  link_pwr_ctrl #(.NUM_RATES(NR), .LOCK_TMO(8), .SETTLE_TMO(12), .DOWN_CYC(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .rate_req_i(rate_req), .tx_busy_i(tx_busy), .rx_lock_i(rx_lock),
    .supply_ok_i(supply_ok), .tx_en_o(tx_en), .rx_en_o(rx_en), .tx_train_o(tx_train),
    .sup_adapt_o(sup_adapt), .freq_o(freq), .data_ok_o(data_ok), .err_o(err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {tx_en, rx_en, tx_train, sup_adapt, data_ok, err};
  endfunction

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    tick(); tick();
    chk(outs() == 0 && freq == 0, "R1 in reset", outs(), 0);
    rst_ni = 1'b1;
    tick(); tick();
    chk(outs() == 0 && freq == 0, "R1 after reset", outs(), 0);

    // wake handshake
    wake_req = 1; tick(); wake_req = 0;
    chk(outs() == 6'b111000 && freq == 0, "R2 waking", outs(), 6'b111000);
    tick(); tick();
    chk(!data_ok && tx_train, "R3 no data before lock", data_ok, 0);
    rx_lock = 1; rate_req = 3'd5; tick();
    chk(outs() == 6'b110010 && freq == 0, "R3 data after lock", outs(), 6'b110010);
    tick(); tick(); tick();
    chk(freq == 0 && data_ok && !sup_adapt, "R4 min rate held", freq, 0);
    supply_ok = 1; tick();
    chk(sup_adapt && freq == 0 && data_ok, "R4 adaptive rail", sup_adapt, 1);
    tick();
    chk(freq == 5 && !data_ok, "R5 retune start", freq, 5);
    tick();
    chk(!data_ok, "R5 stale lock not accepted", data_ok, 0);
    rx_lock = 0; tick(); rx_lock = 1; tick();
    chk(data_ok && freq == 5, "R5 retune done", data_ok, 1);

    // rate vector table
    prev = 5;
    for (int i = 0; i < 7; i++) begin
      rate_req = 3'(V_REQ[i]);
      tick();
      if (V_EXP[i] != prev) begin
        chk(freq == 3'(V_EXP[i]) && !data_ok, "R5 table retune", freq, V_EXP[i]);
        rx_lock = 0; tick(); rx_lock = 1; tick();
        chk(freq == 3'(V_EXP[i]) && data_ok, "R6 table target", freq, V_EXP[i]);
      end else begin
        chk(freq == 3'(V_EXP[i]) && data_ok, "R6 table no change", freq, V_EXP[i]);
      end
      prev = V_EXP[i];
    end

    // shutdown blocked by busy, then wake held during shutdown
    tx_busy = 1; sleep_req = 1; tick(); tick();
    chk(tx_en && data_ok, "R7 busy blocks sleep", tx_en, 1);
    tx_busy = 0; rx_lock = 0; supply_ok = 0; tick();
    chk(outs() == 0 && freq == 0, "R7 shutdown outputs", outs(), 0);
    sleep_req = 0; wake_req = 1; tick(); wake_req = 0;
    chk(!tx_en && !data_ok, "R7 shutdown cycle 2", tx_en, 0);
    tick();
    chk(!tx_en && !tx_train, "R7 shutdown cycle 3", tx_en, 0);
    tick();
    chk(outs() == 0, "R8 off one cycle", outs(), 0);
    tick();
    chk(tx_train && tx_en, "R8 held wake served", tx_train, 1);

    // lock timeout
    repeat (7) tick();
    chk(tx_train && !err, "R9 waking before limit", tx_train, 1);
    tick();
    chk(!tx_en && err, "R9 lock timeout", err, 1);
    tick();
    chk(err && !tx_en, "R9 err held in off", err, 1);
    wake_req = 1; tick(); wake_req = 0;
    chk(!err && tx_train, "R9 err cleared on wake", err, 0);

    // settle timeout
    rx_lock = 1; tick();
    chk(data_ok && !sup_adapt, "R10 min entered", data_ok, 1);
    repeat (11) tick();
    chk(data_ok && !err, "R10 before limit", data_ok, 1);
    tick();
    chk(!tx_en && err, "R10 settle timeout", err, 1);

    // retune timeout with lock never lost
    wake_req = 1; tick(); wake_req = 0;
    tick(); supply_ok = 1; tick();
    chk(sup_adapt && freq == 0, "R11 running", sup_adapt, 1);
    tick();
    chk(freq == 1 && !data_ok, "R11 retune", freq, 1);
    repeat (7) tick();
    chk(tx_en && !data_ok && !err, "R11 before limit", tx_en, 1);
    tick();
    chk(!tx_en && err && freq == 0, "R11 retune timeout", err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule